// File: doc/BRIEF.md
# Instruction Breakpoint Address Comparator

This block watches a stream of retiring instructions and decides, one instruction at a time, whether any programmed breakpoint slot or the vector-catch comparator fires on it. Each instruction arrives with its address, an instruction-set flag (fixed 32-bit encoding or mixed 16/32-bit encoding) and a length flag. Every slot holds a base address, a 4-bit byte-select field, a match/mismatch mode bit and an enable. The slots are evaluated in parallel and the result is registered one cycle later.

The slot and vector-catch settings are plain static inputs, held steady by the surrounding debug logic. The instruction input is a valid/ready stream whose ready is always high: the comparator keeps no state per instruction, so it never applies back-pressure and takes one instruction per clock. Each accepted instruction produces exactly one registered result in the following cycle, flagged by `ev_valid_o`. There is no output handshake, and the consumer must take each result in the cycle it appears.

The output carries the raw breakpoint hit, the index of the lowest-numbered slot that hit, the raw vector-catch hit and one prioritised event kind. A breakpoint outranks vector catch whenever both fire on the same instruction.

Top module: `bkpt_cmp_top`

## Requirements
- R1: A slot whose byte-select field is 0000 never hits, in either mode, whatever its enable and base are.
- R2: For a fixed-set instruction (`in_mixed_i`=0, word-aligned address), an enabled match-mode slot hits when address bits [ADDR_W-1:2] equal those of its base and its byte-select is any nonzero value, 1100 included.
- R3: For a 16-bit mixed-set instruction, an enabled match-mode slot hits when the word addresses are equal and the halfword that holds the instruction is selected: byte-select bits [1:0] not both zero for address bit 1 = 0, bits [3:2] not both zero for address bit 1 = 1.
- R4: A 32-bit mixed-set instruction is matched on its first halfword only. A selection that covers only its second halfword gives no hit, and the instruction at base+2 with byte-select 1111 hits.
- R5: An enabled mismatch-mode slot with nonzero byte-select hits exactly when the address comparison of R2 to R4 fails. A 32-bit mixed-set instruction at base+2 with byte-select 1111 counts as an address match and so gives no hit.
- R6: `bp_hit_o` is the OR of all slot hits, and `bp_slot_o` is the index of the lowest-numbered hitting slot, or 0 when none hits.
- R7: With `vc_en_i`=1, vector catch hits when the instruction address equals the vector address, or when a 32-bit mixed-set instruction sits at vector−2 or vector+2. With `vc_en_i`=0 it never hits.
- R8: `ev_kind_o` is 1 (breakpoint) when a slot hits, else 2 (vector catch) when vector catch hits, else 0 (none).
- R9: All outputs appear in the cycle after the instruction is accepted. They are all zero in the cycle after one with `in_valid_i` low, and in the cycle after a synchronous reset.
- R10: `in_ready_o` is always 1, so every instruction with `in_valid_i` high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_base_i | input | NUM_SLOTS*ADDR_W | Base address per slot, slot 0 in the low bits |
| slot_bsel_i | input | NUM_SLOTS*4 | Byte-select field per slot |
| slot_mism_i | input | NUM_SLOTS | 1 = mismatch mode per slot |
| slot_en_i | input | NUM_SLOTS | Slot enable |
| vc_en_i | input | 1 | Vector-catch enable |
| vc_addr_i | input | ADDR_W | Vector address (halfword aligned) |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Instruction ready, always 1 |
| in_addr_i | input | ADDR_W | Instruction address |
| in_mixed_i | input | 1 | 1 = mixed 16/32-bit set, 0 = fixed 32-bit set |
| in_len32_i | input | 1 | 1 = 32-bit instruction (mixed set) |
| ev_valid_o | output | 1 | Result valid |
| bp_hit_o | output | 1 | Any slot hit |
| bp_slot_o | output | SLOT_W | Lowest hitting slot index |
| vc_hit_o | output | 1 | Vector-catch hit |
| ev_kind_o | output | 2 | Prioritised event: 0 none, 1 breakpoint, 2 vector catch |

## Verification
A wrong halfword selection or straddle decision in one slot shows up on `bp_hit_o` one cycle after the offending instruction, but only when that slot is the sole one hitting. For that reason the stimulus places instructions on, beside and two bytes either side of the slot bases. A priority encoder fault only shows when two or more slots hit together, and then it appears as a wrong `bp_slot_o`. An error in the vector ±2 windows or in the priority shows on `vc_hit_o` or `ev_kind_o` in that same following cycle. Stale registered state shows as nonzero outputs in a cycle after an idle input.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_BKPT   = 2'd1,
    EV_VCATCH = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic              mism_i,
  input  logic [3:0]        bsel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mixed_i,
  output logic              hit_o
);
  logic word_eq, hw_sel, addr_match, armed;

  always_comb begin
    word_eq    = (addr_i[ADDR_W-1:2] == base_i[ADDR_W-1:2]);
    // first halfword of the instruction decides; the second half is never looked at
    hw_sel     = addr_i[1] ? (|bsel_i[3:2]) : (|bsel_i[1:0]);
    addr_match = word_eq & (mixed_i ? hw_sel : 1'b1);
    armed      = en_i & (|bsel_i);
    hit_o      = armed & (addr_match ^ mism_i);
  end
endmodule

// File: rtl/bkpt_vcatch.sv
module bkpt_vcatch #(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] vec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mixed_i,
  input  logic              len32_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] HW_STEP = ADDR_W'(2);
  logic exact, near;

  always_comb begin
    exact = (addr_i[ADDR_W-1:1] == vec_i[ADDR_W-1:1]);
    near  = mixed_i & len32_i &
            ((addr_i[ADDR_W-1:1] == (vec_i - HW_STEP) >> 1) |
             (addr_i[ADDR_W-1:1] == (vec_i + HW_STEP) >> 1));
    hit_o = en_i & (exact | near);
  end
endmodule

// File: rtl/bkpt_prio_enc.sv
module bkpt_prio_enc #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/bkpt_cmp_top.sv
module bkpt_cmp_top
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_base_i,
  input  logic [NUM_SLOTS*4-1:0]      slot_bsel_i,
  input  logic [NUM_SLOTS-1:0]        slot_mism_i,
  input  logic [NUM_SLOTS-1:0]        slot_en_i,
  input  logic                        vc_en_i,
  input  logic [ADDR_W-1:0]           vc_addr_i,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [ADDR_W-1:0]           in_addr_i,
  input  logic                        in_mixed_i,
  input  logic                        in_len32_i,
  output logic                        ev_valid_o,
  output logic                        bp_hit_o,
  output logic [SLOT_W-1:0]           bp_slot_o,
  output logic                        vc_hit_o,
  output logic [1:0]                  ev_kind_o
);
  logic [NUM_SLOTS-1:0] hit_vec;
  logic                 any_hit;
  logic [SLOT_W-1:0]    sel_idx;
  logic                 vc_raw;
  ev_kind_e             kind_nxt;

  assign in_ready_o = 1'b1;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    bkpt_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .en_i   (slot_en_i[g]),
      .mism_i (slot_mism_i[g]),
      .bsel_i (slot_bsel_i[g*4 +: 4]),
      .base_i (slot_base_i[g*ADDR_W +: ADDR_W]),
      .addr_i (in_addr_i),
      .mixed_i(in_mixed_i),
      .hit_o  (hit_vec[g])
    );

    assert_bsel_zero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (slot_bsel_i[g*4 +: 4] == 4'b0000) |-> !hit_vec[g]);
  end

  bkpt_prio_enc #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_prio (
    .req_i(hit_vec),
    .any_o(any_hit),
    .idx_o(sel_idx)
  );

  bkpt_vcatch #(.ADDR_W(ADDR_W)) u_vc (
    .en_i   (vc_en_i),
    .vec_i  (vc_addr_i),
    .addr_i (in_addr_i),
    .mixed_i(in_mixed_i),
    .len32_i(in_len32_i),
    .hit_o  (vc_raw)
  );

  always_comb begin
    if (any_hit)     kind_nxt = EV_BKPT;
    else if (vc_raw) kind_nxt = EV_VCATCH;
    else             kind_nxt = EV_NONE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !in_valid_i) begin
      ev_valid_o <= 1'b0;
      bp_hit_o   <= 1'b0;
      bp_slot_o  <= '0;
      vc_hit_o   <= 1'b0;
      ev_kind_o  <= EV_NONE;
    end else begin
      ev_valid_o <= 1'b1;
      bp_hit_o   <= any_hit;
      bp_slot_o  <= any_hit ? sel_idx : '0;
      vc_hit_o   <= vc_raw;
      ev_kind_o  <= kind_nxt;
    end
  end

  assert_lowest_set_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    any_hit |-> (hit_vec[sel_idx] && ((hit_vec & ((NUM_SLOTS'(1) << sel_idx) - NUM_SLOTS'(1))) == '0)));

  assert_vc_off_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!vc_en_i && in_valid_i) |=> !vc_hit_o);

  assert_bkpt_kind_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_kind_o == EV_BKPT) |-> bp_hit_o);

  assert_vc_kind_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (vc_hit_o && !bp_hit_o) |-> (ev_kind_o == EV_VCATCH));

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(in_valid_i) |-> (!ev_valid_o && !bp_hit_o && !vc_hit_o && ev_kind_o == EV_NONE));
endmodule

// File: tb/bkpt_cmp_top_tb_top.sv
`timescale 1ns/1ps
module bkpt_cmp_top_tb_top;
  localparam int NS = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] sb [NS];
  logic [3:0]    sbs[NS];
  logic          smm[NS];
  logic          sen[NS];
  logic [NS*AW-1:0] base_flat;
  logic [NS*4-1:0]  bsel_flat;
  logic [NS-1:0]    mm_flat, en_flat;
  logic          vc_en = 1'b0;
  logic [AW-1:0] vc_addr = '0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic          in_mixed = 1'b0;
  logic          in_len32 = 1'b0;
  logic          in_ready, ev_valid, bp_hit, vc_hit;
  logic [1:0]    bp_slot, ev_kind;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      base_flat[i*AW +: AW] = sb[i];
      bsel_flat[i*4 +: 4]   = sbs[i];
      mm_flat[i] = smm[i];
      en_flat[i] = sen[i];
    end
  end

  bkpt_cmp_top #(.NUM_SLOTS(NS), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst),
    .slot_base_i(base_flat), .slot_bsel_i(bsel_flat),
    .slot_mism_i(mm_flat), .slot_en_i(en_flat),
    .vc_en_i(vc_en), .vc_addr_i(vc_addr),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_addr_i(in_addr), .in_mixed_i(in_mixed), .in_len32_i(in_len32),
    .ev_valid_o(ev_valid), .bp_hit_o(bp_hit), .bp_slot_o(bp_slot),
    .vc_hit_o(vc_hit), .ev_kind_o(ev_kind)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // R1..R5: expected hit of one slot from the stated rules
  function automatic logic exp_slot(int s, logic [AW-1:0] a, logic mixed);
    logic am;
    if (!sen[s] || sbs[s] == 4'b0000) return 1'b0;
    am = (a[AW-1:2] == sb[s][AW-1:2]);
    if (mixed) am = am && (a[1] ? (sbs[s][3:2] != 2'b00) : (sbs[s][1:0] != 2'b00));
    return smm[s] ? !am : am;
  endfunction

  // R7
  function automatic logic exp_vc(logic [AW-1:0] a, logic mixed, logic l32);
    logic [AW-1:0] ah, vh;
    if (!vc_en) return 1'b0;
    ah = {a[AW-1:1], 1'b0};
    vh = {vc_addr[AW-1:1], 1'b0};
    if (ah == vh) return 1'b1;
    if (mixed && l32 && (ah == vh - 2 || ah == vh + 2)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got {valid,bp,slot,vc,kind}=%b expected %b", req, got, exp);
    end
  endtask

  // drive at a falling edge, register at the rising edge, sample at the next falling edge
  task automatic step(input string req, input logic v, input logic [AW-1:0] a,
                      input logic mixed, input logic l32);
    logic [6:0] exp;
    logic any;
    logic [1:0] idx;
    logic vc;
    in_valid = v; in_addr = a; in_mixed = mixed; in_len32 = l32;
    any = 1'b0; idx = 2'd0;
    for (int i = NS - 1; i >= 0; i--) if (exp_slot(i, a, mixed)) begin any = 1'b1; idx = 2'(i); end
    vc = exp_vc(a, mixed, l32);
    if (!v) exp = '0;
    else exp = {1'b1, any, idx, vc, any ? 2'd1 : (vc ? 2'd2 : 2'd0)};
    @(negedge clk);
    check(req, {ev_valid, bp_hit, bp_slot, vc_hit, ev_kind}, exp);
  endtask

  task automatic clear_slots();
    for (int i = 0; i < NS; i++) begin sb[i] = '0; sbs[i] = '0; smm[i] = 1'b0; sen[i] = 1'b0; end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_slots();
    // R9: reset clears outputs even with valid input
    rst = 1'b1; in_valid = 1'b1; vc_en = 1'b1; vc_addr = 32'h100;
    in_addr = 32'h100;
    @(negedge clk); @(negedge clk);
    check("R9 reset", {ev_valid, bp_hit, bp_slot, vc_hit, ev_kind}, '0);
    rst = 1'b0; vc_en = 1'b0;
    n_tests++;
    if (in_ready !== 1'b1) begin n_fail++; $display("FAIL R10: got %b expected 1", in_ready); end

    // R1: byte-select 0000 in both modes
    sb[0] = 32'h1000; sbs[0] = 4'b0000; sen[0] = 1'b1; smm[0] = 1'b0;
    step("R1 match mode bsel 0", 1'b1, 32'h1000, 1'b0, 1'b1);
    smm[0] = 1'b1;
    step("R1 mismatch mode bsel 0", 1'b1, 32'h2000, 1'b0, 1'b1);
    // R2: fixed set with 1100
    smm[0] = 1'b0; sbs[0] = 4'b1100;
    step("R2 fixed bsel 1100", 1'b1, 32'h1000, 1'b0, 1'b1);
    // R3: 16-bit halfwords
    step("R3 hw0 unselected", 1'b1, 32'h1000, 1'b1, 1'b0);
    step("R3 hw1 selected", 1'b1, 32'h1002, 1'b1, 1'b0);
    // R4: straddling and base+2
    step("R4 second half only", 1'b1, 32'h1000, 1'b1, 1'b1);
    sbs[0] = 4'b0011;
    step("R4 base-2 second half", 1'b1, 32'h0FFE, 1'b1, 1'b1);
    sbs[0] = 4'b1111;
    step("R4 base+2 bsel 1111", 1'b1, 32'h1002, 1'b1, 1'b1);
    // R5: mismatch mode
    smm[0] = 1'b1;
    step("R5 base+2 counts as match", 1'b1, 32'h1002, 1'b1, 1'b1);
    step("R5 other address hits", 1'b1, 32'h1004, 1'b1, 1'b0);
    // R6: lowest index among several
    smm[0] = 1'b0; sen[0] = 1'b0;
    sb[1] = 32'h3000; sbs[1] = 4'b1111; sen[1] = 1'b1;
    sb[3] = 32'h3000; sbs[3] = 4'b0011; sen[3] = 1'b1;
    sb[2] = 32'h3000; sbs[2] = 4'b0001; sen[2] = 1'b1;
    step("R6 lowest of 1,2,3", 1'b1, 32'h3000, 1'b1, 1'b0);
    step("R6 only slot1 at hw1", 1'b1, 32'h3002, 1'b1, 1'b0);
    // R7: vector catch windows
    clear_slots();
    vc_en = 1'b1; vc_addr = 32'h0400;
    step("R7 exact", 1'b1, 32'h0400, 1'b0, 1'b1);
    step("R7 vec-2 32-bit", 1'b1, 32'h03FE, 1'b1, 1'b1);
    step("R7 vec+2 32-bit", 1'b1, 32'h0402, 1'b1, 1'b1);
    step("R7 vec+2 16-bit", 1'b1, 32'h0402, 1'b1, 1'b0);
    vc_en = 1'b0;
    step("R7 disabled", 1'b1, 32'h0400, 1'b0, 1'b1);
    // R8: both hit, breakpoint wins
    vc_en = 1'b1; sb[2] = 32'h0400; sbs[2] = 4'b1111; sen[2] = 1'b1;
    step("R8 bkpt over vcatch", 1'b1, 32'h0400, 1'b0, 1'b1);
    // R9: idle cycle
    step("R9 idle", 1'b0, 32'h0400, 1'b0, 1'b1);

    // random mix around a small address window
    for (int it = 0; it < 600; it++) begin
      logic mixed;
      logic [AW-1:0] a;
      for (int i = 0; i < NS; i++) begin
        sb[i]  = 32'h1000 + 32'(($urandom % 4) * 4);
        sbs[i] = 4'($urandom);
        smm[i] = (($urandom % 6) == 0);
        sen[i] = (($urandom % 4) != 0);
      end
      vc_en   = $urandom % 2;
      vc_addr = 32'h1000 + 32'(($urandom % 8) * 2);
      mixed   = $urandom % 2;
      a = 32'h0FFC + 32'(($urandom % 12) * 2);
      if (!mixed) a[1:0] = 2'b00;
      step("R2/R3/R4/R5/R6/R7/R8 random", (($urandom % 8) != 0), a, mixed, mixed ? 1'($urandom) : 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule